// File: doc/BRIEF.md
# Odd-Width Unsigned Multiplier on a Halving Vertical-and-Crosswise Core

This block multiplies two unsigned operands whose width is odd (the default is 13 bits) and returns the full double-width product. It does not widen the operands to an evenly divisible width. The datapath is exactly the operand width.

Each operand is split into its single top bit and its remaining low bits. A core multiplier of width one less than the operand width forms the product of the two low parts. Each top bit controls a multiplexer. That multiplexer either passes the other operand's low part or passes zero, and the result is added as a cross term shifted up by the core width. One AND gate forms the product of the two top bits, and that bit is placed at the top of the weighting. One adder tree then merges the core product, both cross terms and the AND-gate bit.

The core is built by halving. Each level of the core splits its operands into halves and combines four half-width sub-products. The lowest level is a 3-bit unit that adds its partial products one column at a time, from low to high, and passes a carry from each column to the next. The block is purely combinational. It has no clock, no reset and no pipeline stage, so the product follows the inputs within the same cycle.

Top module: `oddw_mul`

## Requirements
- R1: For all operand pairs, `prod_o` equals the unsigned product of `a_i` and `b_i`, and it is 2N bits wide (26 bits for N = 13).
- R2: When either operand is zero, `prod_o` is zero.
- R3: When bit N-1 of both operands is clear, `prod_o` equals the product of the low N-1 bits of each operand and is below 2^(2N-2).
- R4: When exactly one operand has bit N-1 set, `prod_o` equals the low-part product plus the other operand's low N-1 bits shifted left by N-1.
- R5: When both operands have bit N-1 set, `prod_o` is at least 2^(2N-2). With both operands equal to 2^(N-1), only bit 2N-2 (bit 24) is set.
- R6: All-ones times all-ones gives 2^(2N) - 2^(N+1) + 1 (0x3FFC001 for N = 13).
- R7: For operands below 8, which reach only the lowest 3-bit unit, all 64 pairs give the exact product.
- R8: When one operand is 1, `prod_o` equals the other operand, zero-extended.
- R9: The product is combinational. It is valid in the same cycle that the operands are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N (13) | Unsigned multiplicand |
| b_i | input | N (13) | Unsigned multiplier |
| prod_o | output | 2N (26) | Full unsigned product |

## Verification
The bench applies patterns that exercise different paths through the block.

- Operands with both top bits clear exercise the core alone, so an error in the core's halving or its offsets shows up there first.
- Operands with exactly one top bit set turn on one cross-term multiplexer at a time, so these patterns tell the two multiplexers apart and reveal an error in their shift.
- Operands with the top bit alone, and all-ones operands, exercise the AND-gate term and the carries into the highest product bits.
- Every pair below 8 is applied to isolate the 3-bit column unit.
- A long random run then covers the operand space broadly.

// File: rtl/oddw_mul_pkg.sv
package oddw_mul_pkg;

    // Width of the smallest vertical-and-crosswise unit at the leaves of the core.
    localparam int unsigned LEAF_W = 3;

    // A core width is usable when it is LEAF_W times a power of two.
    function automatic bit core_width_ok(input int unsigned w);
        int unsigned v;
        v = w;
        while (v > LEAF_W && (v % 2) == 0) v = v / 2;
        return v == LEAF_W;
    endfunction

endpackage

// File: rtl/vc3_unit.sv
module vc3_unit (
    input  logic [2:0] x_i,
    input  logic [2:0] y_i,
    output logic [5:0] p_o
);
    logic [1:0] col0;
    logic [2:0] col1, col2, col3;
    logic [1:0] col4;
    logic [3:0] acc1, acc2, acc3, acc4;

    always_comb begin
        // Sum the partial products that fall into each column.
        col0 = {1'b0, x_i[0] & y_i[0]};
        col1 = 3'(x_i[1] & y_i[0]) + 3'(x_i[0] & y_i[1]);
        col2 = 3'(x_i[2] & y_i[0]) + 3'(x_i[1] & y_i[1]) + 3'(x_i[0] & y_i[2]);
        col3 = 3'(x_i[2] & y_i[1]) + 3'(x_i[1] & y_i[2]);
        col4 = {1'b0, x_i[2] & y_i[2]};

        // Pass the carry from each column into the next one up.
        acc1 = 4'(col1);
        acc2 = 4'(col2) + 4'(acc1[3:1]);
        acc3 = 4'(col3) + 4'(acc2[3:1]);
        acc4 = 4'(col4) + 4'(acc3[3:1]);
        p_o  = {acc4[1:0], acc3[0], acc2[0], acc1[0], col0[0]};
    end

    always_comb begin
        // R7
        leaf_exact_chk: assert (p_o == 6'(x_i) * 6'(y_i))
            else $error("leaf product mismatch");
    end
endmodule

// File: rtl/vc_tree.sv
module vc_tree #(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0]   x_i,
    input  logic [W-1:0]   y_i,
    output logic [2*W-1:0] p_o
);
    localparam int unsigned H = W / 2;
    localparam int unsigned P = 2 * W;

    generate
        if (W == oddw_mul_pkg::LEAF_W) begin : g_leaf
            vc3_unit u_leaf (.x_i(x_i), .y_i(y_i), .p_o(p_o));
        end else begin : g_split
            logic [W-1:0] ll, lh, hl, hh;

            vc_tree #(.W(H)) u_ll (.x_i(x_i[H-1:0]), .y_i(y_i[H-1:0]), .p_o(ll));
            vc_tree #(.W(H)) u_lh (.x_i(x_i[H-1:0]), .y_i(y_i[W-1:H]), .p_o(lh));
            vc_tree #(.W(H)) u_hl (.x_i(x_i[W-1:H]), .y_i(y_i[H-1:0]), .p_o(hl));
            vc_tree #(.W(H)) u_hh (.x_i(x_i[W-1:H]), .y_i(y_i[W-1:H]), .p_o(hh));

            // Low product, then both cross terms weighted by H, then the high product weighted by W.
            assign p_o = P'(ll) + (P'(lh) << H) + (P'(hl) << H) + (P'(hh) << W);
        end
    endgenerate

    always_comb begin
        // R2
        zero_operand_chk: assert (!((x_i == '0) || (y_i == '0)) || (p_o == '0))
            else $error("nonzero product from zero operand");
    end
endmodule

// File: rtl/oddw_mul.sv
module oddw_mul #(
    parameter int unsigned N = 13
) (
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   b_i,
    output logic [2*N-1:0] prod_o
);
    localparam int unsigned C = N - 1;
    localparam int unsigned P = 2 * N;

    logic         a_top, b_top, top_and;
    logic [C-1:0] a_low, b_low;
    logic [2*C-1:0] core_p;
    logic [C-1:0] cross_a, cross_b;

    assign a_top = a_i[N-1];
    assign b_top = b_i[N-1];
    assign a_low = a_i[C-1:0];
    assign b_low = b_i[C-1:0];

    vc_tree #(.W(C)) u_core (.x_i(a_low), .y_i(b_low), .p_o(core_p));

    // Each top bit selects the other operand's low part or zero.
    assign cross_a = a_top ? b_low : '0;
    assign cross_b = b_top ? a_low : '0;
    // The one extra gate: the product of the two top bits.
    assign top_and = a_top & b_top;

    assign prod_o = P'(core_p) + (P'(cross_a) << C) + (P'(cross_b) << C) + (P'(top_and) << (2 * C));

    always_comb begin
        // R3
        core_only_chk: assert (a_top || b_top || (prod_o == P'(core_p)))
            else $error("product differs from core with top bits clear");
        // R5
        top_pair_chk: assert (!top_and || prod_o[P-1:P-2] != 2'b00)
            else $error("top pair product too small");
        // R1
        width_bound_chk: assert (a_top || prod_o[P-1] == 1'b0)
            else $error("product exceeds bound with top bit of a clear");
    end
endmodule

// File: tb/oddw_mul_tb.sv
module oddw_mul_tb;
    localparam int N = 13;
    localparam int C = N - 1;

    logic clk = 1'b0;
    logic [N-1:0]   a, b;
    logic [2*N-1:0] prod;
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    oddw_mul #(.N(N)) u_dut (.a_i(a), .b_i(b), .prod_o(prod));

    longint exp_q[$];

    // Operands are driven just after the rising edge; the product is sampled at the falling edge of the same cycle (R9).
    task automatic apply(input string req, input longint av, input longint bv);
        longint expv;
        @(posedge clk);
        #0.5;
        a = N'(av);
        b = N'(bv);
        exp_q.push_back((av & ((1 << N) - 1)) * (bv & ((1 << N) - 1)));
        @(negedge clk);
        expv = exp_q.pop_front();
        n_run++;
        if (longint'(prod) != expv) begin
            n_fail++;
            $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, prod, expv);
        end
    endtask

    initial begin
        longint ones, msb, lowmask;
        ones    = (1 << N) - 1;
        msb     = 1 << C;
        lowmask = (1 << C) - 1;
        a = '0;
        b = '0;
        @(negedge clk);
        n_run++;
        if (prod != '0) begin
            n_fail++;
            $display("FAIL R2 initial actual=%0d expected=0", prod);
        end

        // R2 zero operand
        apply("R2", 0, 0);
        apply("R2", 0, ones);
        apply("R2", ones, 0);
        apply("R2", 0, msb);
        // R8 identity
        apply("R8", 1, ones);
        apply("R8", msb, 1);
        apply("R8", 1, 1);
        apply("R8", 1234, 1);
        // R6 all ones
        apply("R6", ones, ones);
        // R5 top bits
        apply("R5", msb, msb);
        apply("R5", msb | 1, msb | lowmask);
        apply("R5", ones, msb);
        // R4 one top bit
        apply("R4", msb, lowmask);
        apply("R4", lowmask, msb | 5);
        apply("R4", msb | 2730, 1365);
        apply("R4", 4095, msb | 4095);
        // R3 low parts only
        apply("R3", lowmask, lowmask);
        apply("R3", 2730, 1365);
        apply("R3", 64, 63);
        apply("R3", 4032, 7);
        // R7 every leaf pair
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                apply("R7", i, j);
        // R1 random pairs
        for (int k = 0; k < 3000; k++)
            apply("R1", longint'($urandom) & ones, longint'($urandom) & ones);
        // R1 walking single bits
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                apply("R1", 1 << i, 1 << j);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule